// File: doc/BRIEF.md
# TRS Timing Lock Detector

This block watches a received digital-video word stream that arrives one word per pixel clock, qualified by a valid strobe. It works from already decoded timing-reference strobes, one marking the end of active video and one marking the start of active video. It judges whether those markers land at a steady place in every line. A word counter advances on valid words only and restarts at each end-of-active-video marker. The index of each marker is measured against that counter.

A line counts as a match when its closing end marker and its single start marker sit at the same indices as in the reference line. After a run of matching lines the block raises its lock output. While locked it tolerates a bounded run of faults before it lets go. A fault is either a marker that never arrived inside a small window, or a line whose marker positions changed. A correctly timed line wipes the fault run. When an expected end marker is overdue, the block counts on as if the marker had landed on time, so later lines are still measured against the right grid.

Top module: `trs_lock_detector`

## Requirements
- R1: The word counter moves only on cycles with `word_valid` high. A cycle with `word_valid` low changes no state, even when `eav_stb` or `sav_stb` is high.
- R2: Indices count from the last end marker, which is index 0. The first end marker after reset only starts counting. Each later end marker closes a line whose length is its own index. The line matches when that length equals the reference length and exactly one start marker was seen in the line, at the reference start index.
- R3: `trs_locked` rises once LOCK_LINES (6) consecutive lines share the same timing. The line that set the reference counts as the first of these lines. The output goes high on the cycle after the word carrying the end marker that closes the sixth line.
- R4: Once a reference exists, a valid word at index reference length + MISS_WIN (4) that carries no end marker is a miss. Counting then continues as though an end marker had been seen at the reference length.
- R5: While locked, MISS_TOL (4) consecutive faults leave `trs_locked` high. The next consecutive fault drops it.
- R6: A line that does not match becomes the new reference and restarts the matching run at one. While locked, it also counts as a fault.
- R7: A matching line clears the consecutive-fault count.
- R8: An end marker that arrives on exactly the word at which a miss would be declared is treated as a mismatched line, which is one fault, not as a miss as well.
- R9: A synchronous active-high `rst` clears all counters and references, and `trs_locked` is low in the cycle after a reset edge.
- R10: A miss while unlocked resets the matching run to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| word_valid | input | 1 | Qualifies the current word |
| eav_stb | input | 1 | Current word is an end-of-active-video marker |
| sav_stb | input | 1 | Current word is a start-of-active-video marker |
| trs_locked | output | 1 | Marker timing judged stable |

## Verification
The collision that matters is between the overdue-marker timeout and a late end marker on the same word. The block could count that word as a miss and also as a mismatched line, and a double count would spend two faults of the tolerance at once. The bench spends three faults on missing markers. It then delivers an end marker exactly on the timeout word and checks that lock survives, because the fault run stands at four. It then checks that the next mismatched line drops the lock.

// File: rtl/trs_lock_pkg.sv
`timescale 1ns/1ps
package trs_lock_pkg;

    // Per-word strobes after the valid qualifier is attached.
    typedef struct packed {
        logic valid;
        logic eav;
        logic sav;
    } word_evt_t;

    // Outcome of the current word for the lock controller.
    typedef enum logic [1:0] {
        LINE_NONE = 2'd0,
        LINE_GOOD = 2'd1,
        LINE_BAD  = 2'd2,
        LINE_MISS = 2'd3
    } line_verdict_e;

    function automatic logic is_fault(line_verdict_e v);
        return (v == LINE_BAD) || (v == LINE_MISS);
    endfunction

endpackage

// File: rtl/trs_word_counter.sv
`timescale 1ns/1ps
module trs_word_counter #(
    parameter int unsigned CNT_W    = 13,
    parameter int unsigned MISS_WIN = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             word_valid,
    input  logic             eav_stb,
    input  logic             have_ref,
    input  logic [CNT_W-1:0] ref_len,
    output logic             started,
    output logic [CNT_W-1:0] idx,
    output logic             timeout
);
    localparam int unsigned EXT_W = CNT_W + 1;
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [CNT_W-1:0] wcnt;
    logic [EXT_W-1:0] limit;

    // Index of the word now on the input, saturating.
    always_comb begin
        idx   = (wcnt == CNT_MAX) ? CNT_MAX : wcnt + CNT_W'(1);
        limit = {1'b0, ref_len} + EXT_W'(MISS_WIN);
        timeout = word_valid && !eav_stb && started && have_ref
                  && ({1'b0, idx} >= limit);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wcnt    <= '0;
            started <= 1'b0;
        end else if (word_valid) begin
            if (eav_stb) begin
                wcnt    <= '0;
                started <= 1'b1;
            end else if (started) begin
                if (timeout) begin
                    // Re-anchor on the expected marker position.
                    wcnt <= idx - ref_len;
                end else begin
                    wcnt <= idx;
                end
            end
        end
    end

endmodule

// File: rtl/trs_line_capture.sv
`timescale 1ns/1ps
module trs_line_capture
    import trs_lock_pkg::*;
#(
    parameter int unsigned CNT_W = 13
) (
    input  logic             clk,
    input  logic             rst,
    input  word_evt_t        evt,
    input  logic             started,
    input  logic [CNT_W-1:0] idx,
    input  logic             timeout,
    output line_verdict_e    verdict,
    output logic             have_ref,
    output logic [CNT_W-1:0] ref_len
);
    logic [CNT_W-1:0] ref_sav;
    logic [CNT_W-1:0] sav_pos;
    logic [1:0]       sav_cnt;
    logic             line_end;
    logic             sav_hit;
    logic             line_match;

    always_comb begin
        line_end   = evt.valid && evt.eav && started;
        sav_hit    = evt.valid && evt.sav && !evt.eav && started && !timeout;
        line_match = have_ref && (idx == ref_len)
                     && (sav_cnt == 2'd1) && (sav_pos == ref_sav);
        if (line_end) begin
            verdict = line_match ? LINE_GOOD : LINE_BAD;
        end else if (timeout) begin
            verdict = LINE_MISS;
        end else begin
            verdict = LINE_NONE;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ref_len  <= '0;
            ref_sav  <= '0;
            have_ref <= 1'b0;
            sav_pos  <= '0;
            sav_cnt  <= '0;
        end else if (line_end) begin
            sav_cnt <= '0;
            if (!line_match) begin
                ref_len  <= idx;
                ref_sav  <= (sav_cnt == 2'd1) ? sav_pos : '0;
                have_ref <= 1'b1;
            end
        end else if (timeout) begin
            sav_cnt <= '0;
        end else if (sav_hit) begin
            sav_cnt <= (sav_cnt == 2'd2) ? 2'd2 : sav_cnt + 2'd1;
            sav_pos <= idx;
        end
    end

endmodule

// File: rtl/trs_lock_ctrl.sv
`timescale 1ns/1ps
module trs_lock_ctrl
    import trs_lock_pkg::*;
#(
    parameter int unsigned LOCK_LINES = 6,
    parameter int unsigned MISS_TOL   = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  line_verdict_e verdict,
    output logic          locked
);
    localparam int unsigned RUN_W = $clog2(LOCK_LINES + 1);
    localparam int unsigned FLT_W = $clog2(MISS_TOL + 2);
    localparam logic [RUN_W-1:0] RUN_TOP = RUN_W'(LOCK_LINES);
    localparam logic [FLT_W-1:0] FLT_TOP = FLT_W'(MISS_TOL);

    logic [RUN_W-1:0] run_cnt;
    logic [FLT_W-1:0] fault_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            run_cnt   <= '0;
            fault_cnt <= '0;
            locked    <= 1'b0;
        end else if (verdict == LINE_GOOD) begin
            fault_cnt <= '0;
            if (run_cnt + RUN_W'(1) >= RUN_TOP) begin
                run_cnt <= RUN_TOP;
                locked  <= 1'b1;
            end else begin
                run_cnt <= run_cnt + RUN_W'(1);
            end
        end else if (is_fault(verdict)) begin
            run_cnt <= (verdict == LINE_BAD) ? RUN_W'(1) : '0;
            if (locked) begin
                if (fault_cnt == FLT_TOP) begin
                    locked    <= 1'b0;
                    fault_cnt <= '0;
                end else begin
                    fault_cnt <= fault_cnt + FLT_W'(1);
                end
            end
        end
    end

endmodule

// File: rtl/trs_lock_detector.sv
`timescale 1ns/1ps
module trs_lock_detector
    import trs_lock_pkg::*;
#(
    parameter int unsigned CNT_W      = 13,
    parameter int unsigned LOCK_LINES = 6,
    parameter int unsigned MISS_TOL   = 4,
    parameter int unsigned MISS_WIN   = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic word_valid,
    input  logic eav_stb,
    input  logic sav_stb,
    output logic trs_locked
);
    word_evt_t        evt;
    logic             started;
    logic [CNT_W-1:0] idx;
    logic             timeout;
    logic             have_ref;
    logic [CNT_W-1:0] ref_len;
    line_verdict_e    verdict;

    assign evt = '{valid: word_valid, eav: eav_stb, sav: sav_stb};

    trs_word_counter #(
        .CNT_W    (CNT_W),
        .MISS_WIN (MISS_WIN)
    ) u_count (
        .clk        (clk),
        .rst        (rst),
        .word_valid (evt.valid),
        .eav_stb    (evt.eav),
        .have_ref   (have_ref),
        .ref_len    (ref_len),
        .started    (started),
        .idx        (idx),
        .timeout    (timeout)
    );

    trs_line_capture #(
        .CNT_W (CNT_W)
    ) u_capture (
        .clk      (clk),
        .rst      (rst),
        .evt      (evt),
        .started  (started),
        .idx      (idx),
        .timeout  (timeout),
        .verdict  (verdict),
        .have_ref (have_ref),
        .ref_len  (ref_len)
    );

    trs_lock_ctrl #(
        .LOCK_LINES (LOCK_LINES),
        .MISS_TOL   (MISS_TOL)
    ) u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .verdict (verdict),
        .locked  (trs_locked)
    );

endmodule

// File: rtl/trs_lock_checker.sv
`timescale 1ns/1ps
module trs_lock_checker
    import trs_lock_pkg::*;
#(
    parameter int unsigned CNT_W    = 13,
    parameter int unsigned MISS_WIN = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             word_valid,
    input logic             trs_locked,
    input line_verdict_e    verdict,
    input logic             have_ref,
    input logic [CNT_W-1:0] idx,
    input logic [CNT_W-1:0] ref_len
);
    localparam int unsigned EXT_W = CNT_W + 1;

    // R9: reset forces the lock low on the next edge.
    assert_reset_clears_R9: assert property (@(posedge clk)
        rst |=> !trs_locked);

    // R1: an idle cycle never moves the lock.
    assert_idle_hold_R1: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(word_valid)) |-> $stable(trs_locked));

    // R3: lock only rises after a matching line.
    assert_lock_rise_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(trs_locked) |-> ($past(verdict) == LINE_GOOD));

    // R5: lock only falls after a fault.
    assert_lock_fall_R5: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $fell(trs_locked))
        |-> ($past(verdict) == LINE_BAD || $past(verdict) == LINE_MISS));

    // R7: a matching line never releases the lock.
    assert_good_keeps_R7: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(trs_locked) && $past(verdict) == LINE_GOOD)
        |-> trs_locked);

    // R4: the counter never runs past the miss window of the reference.
    assert_miss_window_R4: assert property (@(posedge clk) disable iff (rst)
        have_ref |-> ({1'b0, idx} <= {1'b0, ref_len} + EXT_W'(MISS_WIN)));

endmodule

bind trs_lock_detector trs_lock_checker #(
    .CNT_W    (CNT_W),
    .MISS_WIN (MISS_WIN)
) u_checker (
    .clk        (clk),
    .rst        (rst),
    .word_valid (word_valid),
    .trs_locked (trs_locked),
    .verdict    (verdict),
    .have_ref   (have_ref),
    .idx        (idx),
    .ref_len    (ref_len)
);

// File: tb/tb_trs_lock_detector.sv
`timescale 1ns/1ps
module tb_trs_lock_detector;
    localparam int CMAX  = 8191;
    localparam int LOCKN = 6;
    localparam int TOL   = 4;
    localparam int WIN   = 4;
    localparam int LEN   = 40;
    localparam int SAVI  = 12;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic word_valid = 1'b0;
    logic eav_stb = 1'b0;
    logic sav_stb = 1'b0;
    logic trs_locked;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    bit running = 1'b0;
    string cur_req = "R9";

    always #5 clk = ~clk;

    trs_lock_detector dut (
        .clk        (clk),
        .rst        (rst),
        .word_valid (word_valid),
        .eav_stb    (eav_stb),
        .sav_stb    (sav_stb),
        .trs_locked (trs_locked)
    );

    // Behavioural reference model.
    bit m_started, m_ref_ok, m_locked;
    int m_pos, m_rlen, m_rsav, m_savs, m_savp, m_run, m_flt, here;

    task automatic model_good();
        m_flt = 0;
        if (m_run + 1 >= LOCKN) begin
            m_run = LOCKN;
            m_locked = 1'b1;
        end else begin
            m_run++;
        end
    endtask

    task automatic model_fault(bit bad);
        m_run = bad ? 1 : 0;
        if (m_locked) begin
            if (m_flt == TOL) begin
                m_locked = 1'b0;
                m_flt = 0;
            end else begin
                m_flt++;
            end
        end
    endtask

    always @(posedge clk) begin
        if (rst) begin
            m_started = 0; m_ref_ok = 0; m_locked = 0;
            m_pos = 0; m_rlen = 0; m_rsav = 0; m_savs = 0; m_savp = 0;
            m_run = 0; m_flt = 0;
        end else if (word_valid) begin
            if (!m_started) begin
                if (eav_stb) begin
                    m_started = 1; m_pos = 0; m_savs = 0;
                end
            end else begin
                here = (m_pos < CMAX) ? m_pos + 1 : CMAX;
                if (eav_stb) begin
                    if (m_ref_ok && here == m_rlen && m_savs == 1 && m_savp == m_rsav) begin
                        model_good();
                    end else begin
                        model_fault(1'b1);
                        m_rlen = here;
                        m_rsav = (m_savs == 1) ? m_savp : 0;
                        m_ref_ok = 1;
                    end
                    m_pos = 0; m_savs = 0;
                end else if (m_ref_ok && here >= m_rlen + WIN) begin
                    model_fault(1'b0);
                    m_pos = here - m_rlen;
                    m_savs = 0;
                end else begin
                    if (sav_stb) begin
                        m_savs = (m_savs < 2) ? m_savs + 1 : 2;
                        m_savp = here;
                    end
                    m_pos = here;
                end
            end
        end
    end

    task automatic check(bit act, bit exp, string req);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: trs_locked=%0b expected %0b at %0t", req, act, exp, $time);
        end
    endtask

    // Compare against the model on every clock, away from the edge.
    always @(negedge clk) begin
        if (running && !rst) check(trs_locked, m_locked, cur_req);
    end

    task automatic drive(bit v, bit e, bit s);
        @(negedge clk);
        word_valid = v;
        eav_stb    = e;
        sav_stb    = s;
    endtask

    task automatic send_line(int len, int sav_at, bit eav_on, int gap);
        for (int i = 0; i < len; i++) begin
            drive(1'b1, eav_on && (i == 0), i == sav_at);
            if (gap > 0 && (i % gap) == gap - 1) drive(1'b0, 1'b1, 1'b1);
        end
    endtask

    task automatic lines(int n, int gap);
        for (int k = 0; k < n; k++) send_line(LEN, SAVI, 1'b1, gap);
    endtask

    task automatic missing(int n);
        for (int k = 0; k < n; k++) send_line(LEN, SAVI, 1'b0, 0);
    endtask

    task automatic settle_check(bit exp, string req);
        drive(1'b0, 1'b0, 1'b0);
        @(posedge clk);
        @(negedge clk);
        check(trs_locked, exp, req);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(trs_locked, 1'b0, "R9");
        rst = 1'b0;
        running = 1'b1;

        // R1 R2 R3: six lines of steady timing with idle gaps carrying stray strobes.
        cur_req = "R3";
        lines(6, 7);
        settle_check(1'b0, "R3");
        lines(1, 7);
        settle_check(1'b1, "R3");
        cur_req = "R1";
        lines(1, 3);
        settle_check(1'b1, "R1");

        // R4 R5 R7: tolerated missing markers, cleared by a good line.
        cur_req = "R4";
        missing(4);
        settle_check(1'b1, "R5");
        lines(1, 0);
        cur_req = "R7";
        missing(4);
        settle_check(1'b1, "R7");
        cur_req = "R5";
        missing(1);
        settle_check(1'b0, "R5");

        // Relock.
        cur_req = "R3";
        lines(7, 5);
        settle_check(1'b1, "R3");

        // R6: repeated mismatched lengths while locked.
        cur_req = "R6";
        send_line(44, SAVI, 1'b1, 0);
        send_line(40, SAVI, 1'b1, 0);
        send_line(44, SAVI, 1'b1, 0);
        send_line(40, SAVI, 1'b1, 0);
        send_line(44, SAVI, 1'b1, 0);
        settle_check(1'b1, "R6");
        send_line(40, SAVI, 1'b1, 0);
        settle_check(1'b0, "R6");
        lines(7, 0);
        settle_check(1'b1, "R6");
        send_line(LEN, SAVI + 1, 1'b1, 0);
        lines(3, 0);
        settle_check(1'b1, "R6");

        // R8: end marker on the timeout word counts once.
        cur_req = "R8";
        missing(2);
        send_line(44, SAVI, 1'b0, 0);
        send_line(LEN, SAVI, 1'b1, 0);
        settle_check(1'b1, "R8");
        send_line(LEN, SAVI, 1'b1, 0);
        settle_check(1'b0, "R8");

        // R10: a miss while unlocked restarts the run.
        cur_req = "R10";
        lines(3, 0);
        missing(1);
        lines(5, 0);
        settle_check(1'b0, "R10");
        lines(1, 0);
        settle_check(1'b1, "R10");

        // R9: reset in the middle of lock.
        cur_req = "R9";
        running = 1'b0;
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check(trs_locked, 1'b0, "R9");
        rst = 1'b0;

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run did not finish, actual hung expected done");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule